// File: doc/BRIEF.md
# Indirect RAM Access Window

This block gives a host bus access to a 256-byte on-chip RAM through two registers in a 32-entry register window. One register holds the RAM pointer. The other is a data port. A write to the data port stores a byte at the pointed location, and a read from it returns that byte. A burst-enable input comes from a control register elsewhere. When it is high, every data-port access advances the pointer by one, so a whole block of RAM can be streamed through one register address. The pointer wraps from the top of the RAM back to zero.

A power-fail input shuts the window off. While it is high, no access reaches the RAM or the pointer, and reads return zero. Every other address in the window is reserved. Reserved addresses read as zero and ignore writes. The bus is synchronous, and each strobe lasts one cycle.

Top module: `ram_window_port`

## Requirements
- R1: After reset the pointer reads 00h and `rd_data` is 00h.
- R2: A write to register address 10h loads `wr_data` into the pointer. A read of 10h returns the pointer value.
- R3: A write to register address 13h stores `wr_data` at the RAM location the pointer selects. A read of 13h returns the byte at that location. Read data appears on `rd_data` in the cycle after the strobe.
- R4: When `burst_en` is low in the strobe cycle, accesses to 13h leave the pointer unchanged.
- R5: When `burst_en` is high in the strobe cycle, each read or write of 13h advances the pointer by one after the access. Accesses to 10h and to reserved addresses never advance it.
- R6: The pointer wraps from FFh to 00h when it advances.
- R7: While `pfail` is high, writes change neither the RAM nor the pointer, reads return 00h, and the pointer does not advance.
- R8: Every register address other than 10h and 13h reads as 00h and ignores writes.
- R9: `rd_data` is 00h in any cycle that follows a cycle without a read strobe.
- R10: When both strobes are high in the same cycle, the write is performed and the read is dropped, so the next `rd_data` is 00h. In burst mode the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pfail | input | 1 | Power-fail; blocks all access while high |
| burst_en | input | 1 | Pointer auto-advance enable, sampled with each strobe |
| reg_addr | input | 5 | Register window address |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after a read strobe |

## Verification
Read data is due one clock after its strobe, through a single output register. The pointer advance and the RAM write take effect at the same edge that samples the strobe. The bench therefore drives strobes on the falling edge and reads `rd_data` at the next falling edge, with one rising edge in between. A read issued right after a write or a pointer load already sees the new state. Checks that `rd_data` falls back to zero are taken one idle cycle after the last read.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;
  localparam int unsigned REG_AW   = 5;
  localparam logic [REG_AW-1:0] REG_PTR  = 5'h10;
  localparam logic [REG_AW-1:0] REG_DATA = 5'h13;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PTR  = 2'd1,
    ACC_DATA = 2'd2,
    ACC_RESV = 2'd3
  } acc_e;
endpackage

// File: rtl/ramwin_decode.sv
module ramwin_decode
  import ramwin_pkg::*;
(
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              pfail,
  output acc_e              acc,
  output logic              acc_wr,
  output logic              acc_rd
);
  logic any_stb;

  always_comb begin
    any_stb = (wr_stb || rd_stb) && !pfail;
    acc_wr  = wr_stb && !pfail;
    acc_rd  = rd_stb && !wr_stb && !pfail;
    if (!any_stb)                  acc = ACC_NONE;
    else if (reg_addr == REG_PTR)  acc = ACC_PTR;
    else if (reg_addr == REG_DATA) acc = ACC_DATA;
    else                           acc = ACC_RESV;
  end
endmodule

// File: rtl/ramwin_pointer.sv
module ramwin_pointer #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load || step;
    if (load) ptr_d = load_val;
    else      ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val)) else $error("pointer load lost"); // R2
endmodule

// File: rtl/ramwin_array.sv
module ramwin_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb rdata = mem[addr];
endmodule

// File: rtl/ram_window_port.sv
module ram_window_port
  import ramwin_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfail,
  input  logic              burst_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data
);
  localparam int unsigned PAD = (DW > AW) ? DW - AW : 0;

  logic          rst_meta, rst_sync;
  acc_e          acc;
  logic          acc_wr, acc_rd;
  logic [AW-1:0] ptr;
  logic [DW-1:0] ram_q;
  logic          ptr_load, ptr_step, ram_we;
  logic [DW-1:0] rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ramwin_decode u_dec (
    .reg_addr (reg_addr),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .pfail    (pfail),
    .acc      (acc),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd)
  );

  always_comb begin
    ptr_load = (acc == ACC_PTR) && acc_wr;
    ptr_step = (acc == ACC_DATA) && burst_en;
    ram_we   = (acc == ACC_DATA) && acc_wr;
  end

  ramwin_pointer #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (ptr_load),
    .load_val (wr_data[AW-1:0]),
    .step     (ptr_step),
    .ptr      (ptr)
  );

  ramwin_array #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ptr),
    .wdata (wr_data),
    .rdata (ram_q)
  );

  always_comb begin
    rd_d = '0;
    if (acc_rd) begin
      case (acc)
        ACC_PTR:  rd_d = {{PAD{1'b0}}, ptr};
        ACC_DATA: rd_d = ram_q;
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) rd_data <= '0;
    else           rd_data <= rd_d;
  end

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_sync)
    (acc == ACC_DATA && burst_en) |=> ptr == AW'($past(ptr) + 1'b1)) else $error("step"); // R5
  AST_NOBURST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    (acc == ACC_DATA && !burst_en) |=> $stable(ptr)) else $error("hold"); // R4
  AST_PFAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync)
    pfail |=> $stable(ptr) && rd_data == '0) else $error("pfail"); // R7
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    (rd_stb && reg_addr != REG_PTR && reg_addr != REG_DATA) |=> rd_data == '0) else $error("resv"); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    !rd_stb |=> rd_data == '0) else $error("idle"); // R9
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_sync)
    (rd_stb && wr_stb) |=> rd_data == '0) else $error("collide"); // R10
endmodule

// File: tb/ram_window_port_test.sv
`timescale 1ns/1ps
module ram_window_port_test;
  logic       clk = 1'b0;
  logic       rst_n, pfail, burst_en, wr_stb, rd_stb;
  logic [4:0] reg_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] model [256];
  int tests = 0, fails = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  ram_window_port uut (
    .clk(clk), .rst_n(rst_n), .pfail(pfail), .burst_en(burst_en),
    .reg_addr(reg_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pfail = 1'b0; burst_en = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    reg_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    bus_rd(5'h10, got); check("R1 pointer", got, 8'h00);

    // R3 R5 R6 burst fill of whole RAM from 00h, wraps to 00h
    burst_en = 1'b1;
    bus_wr(5'h10, 8'h00);
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'((i * 37 + 11) & 8'hFF);
      bus_wr(5'h13, model[i]);
    end
    bus_rd(5'h10, got); check("R6 wrap after fill", got, 8'h00);
    for (int i = 0; i < 256; i++) begin
      bus_rd(5'h13, got); check("R3 R5 burst read", got, model[i]);
    end
    bus_rd(5'h10, got); check("R6 wrap after read", got, 8'h00);
    @(negedge clk); check("R9 idle zero", rd_data, 8'h00);

    // R2 pointer loads, R5 no step on 10h access
    for (int p = 0; p < 256; p += 17) begin
      bus_wr(5'h10, 8'(p)); bus_rd(5'h10, got); check("R2 R5 ptr load", got, 8'(p));
    end

    // R4 burst off
    burst_en = 1'b0;
    bus_wr(5'h10, 8'h5A);
    bus_wr(5'h13, 8'hC3); bus_wr(5'h13, 8'h3C); model[8'h5A] = 8'h3C;
    bus_rd(5'h13, got); check("R4 same loc", got, 8'h3C);
    bus_rd(5'h13, got); check("R4 same loc again", got, 8'h3C);
    bus_rd(5'h10, got); check("R4 ptr held", got, 8'h5A);
    bus_rd(5'h13, got); check("R3 neighbour kept", got, 8'h3C);
    bus_wr(5'h10, 8'h5B); bus_rd(5'h13, got); check("R3 neighbour", got, model[8'h5B]);

    // R6 explicit wrap from FFh
    burst_en = 1'b1;
    bus_wr(5'h10, 8'hFF);
    bus_rd(5'h13, got); check("R3 top loc", got, model[255]);
    bus_rd(5'h10, got); check("R6 FF to 00", got, 8'h00);

    // R8 reserved addresses, burst on so any step would show
    bus_wr(5'h10, 8'h20);
    for (int a = 0; a < 32; a++) begin
      if (a != 16 && a != 19) begin
        bus_wr(5'(a), 8'hFF);
        bus_rd(5'(a), got); check("R8 resv reads 0", got, 8'h00);
      end
    end
    bus_rd(5'h10, got); check("R8 R5 ptr untouched", got, 8'h20);
    bus_rd(5'h13, got); check("R8 ram untouched", got, model[8'h20]);

    // R7 power fail
    bus_wr(5'h10, 8'h40);
    pfail = 1'b1;
    bus_wr(5'h10, 8'h99);
    bus_wr(5'h13, 8'hEE);
    bus_rd(5'h13, got); check("R7 read zero", got, 8'h00);
    bus_rd(5'h10, got); check("R7 ptr read zero", got, 8'h00);
    pfail = 1'b0;
    bus_rd(5'h10, got); check("R7 ptr frozen", got, 8'h40);
    bus_rd(5'h13, got); check("R7 ram kept", got, model[8'h40]);

    // R10 collision: write wins, read dropped, single step
    bus_wr(5'h10, 8'h70);
    @(negedge clk);
    reg_addr = 5'h13; wr_data = 8'hA5; wr_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    check("R10 read dropped", rd_data, 8'h00);
    bus_rd(5'h10, got); check("R10 one step", got, 8'h71);
    bus_wr(5'h10, 8'h70);
    bus_rd(5'h13, got); check("R10 write done", got, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule